// File: doc/BRIEF.md
# Multichannel TDM Lane Repacker

This block moves a time-division multiplexed set of channels from one vector of parallel wires onto another. Each side carries C channels at some per-channel sample rate over a clock running at rate R. The number of wires on a side is the aggregate rate C·S divided by R, rounded up. The input side uses the upstream sample rate. The output side uses that rate scaled by an interpolation factor and divided by a decimation factor. With 10 channels at 20 MSPS and a 100 MHz clock, the input side therefore needs 2 lanes. An interpolate-by-2 stage widens the output to 4 lanes. A decimate-by-5 stage narrows it to 1 lane.

Channels are laid out round-robin. In a given cycle, wire lane l carries channel `base + l`, where `base` is the channel index of lane 0. The block gathers one complete frame of samples from the input vector. Once the last channel of that frame has arrived, it replays the frame on the output vector over `ceil(C/L_out)` consecutive cycles. The output is tagged with a frame-start strobe, a per-lane valid and the channel index of lane 0, so a downstream stage can recover each channel from the lane number and the tag. Upstream slots must arrive in ascending channel order. For a narrowing (decimating) output, input frames must be spaced at least one output frame apart.

Top module: `tdm_lane_repacker`

## Requirements
- R1: Lane counts are derived from parameters. Input lanes = ceil(CH_NUM·SMP_RATE / CLK_RATE). Output lanes = ceil(CH_NUM·SMP_RATE·RATE_UP / (CLK_RATE·RATE_DOWN)). With the defaults (10, 20, 100, up 2, down 1) that is 2 input lanes and 4 output lanes. With up 1 and down 5 it is 2 input lanes and 1 output lane. Sample field k of a data port occupies bits [16k+15:16k].
- R2: In a cycle with `in_valid_i` high, input lane l holds the sample of channel `in_chan_i + l`. Cycles with `in_valid_i` low leave the captured frame unchanged, whatever their data and channel index.
- R3: A valid input cycle with `in_chan_i + IN_LANES >= CH_NUM` completes a frame. In the very next cycle the output shows slot 0 of that frame with `out_sof_o` high. This also holds when the previous output frame is still being sent.
- R4: Output slot s occupies one cycle, s = 0 … ceil(CH_NUM/OUT_LANES)−1, and the slots follow in consecutive cycles. In slot s, lane l carries channel s·OUT_LANES + l, and `out_chan_o` equals s·OUT_LANES.
- R5: An output lane whose channel is CH_NUM or above has valid low and data zero. Outside a frame, every valid is low, and `out_sof_o`, `out_chan_o` and `out_data_o` are zero.
- R6: `out_sof_o` is high only in slot 0.
- R7: Unpacking the output by channel tag returns every channel's sample unchanged and in channel order.
- R8: A decimating configuration with a single output lane sends the frame one channel per cycle over CH_NUM cycles.
- R9: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input vector holds a slot |
| in_chan_i | input | CH_W | Channel index carried by input lane 0 |
| in_data_i | input | IN_LANES·DATA_W | Input lane vector |
| out_valid_o | output | OUT_LANES | Per-lane valid of the output slot |
| out_chan_o | output | CH_W | Channel index carried by output lane 0 |
| out_sof_o | output | 1 | Output frame start (slot 0) |
| out_data_o | output | OUT_LANES·DATA_W | Output lane vector |

## Verification
A stuck or skipped slot counter shows up in the cycle after the fault as an `out_chan_o` tag that fails to advance by the output lane count, or as a lane-valid count that disagrees with the channels remaining. A missed or false frame-completion decode shows up one cycle after the last input slot: `out_sof_o` is either absent or appears without a completed frame. A mis-steered capture write does not change any tag or strobe. It appears only as wrong data when the affected channel is replayed, so every lane of every slot is compared against the sample sent for that channel. Frames use several base/step patterns, an invalid gap cycle inside a frame, and back-to-back frames.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int width_of(input int count);
    return (count <= 2) ? 1 : $clog2(count);
  endfunction
endpackage

// File: rtl/tdm_capture.sv
module tdm_capture
  import tdm_pkg::*;
#(
  parameter int CH_NUM = 10,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int CH_W   = 4
)(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [CH_W-1:0]            chan_i,
  input  logic [LANES*DATA_W-1:0]    data_i,
  output logic                       frame_o,
  output logic [CH_NUM*DATA_W-1:0]   frame_data_o
);
  logic [DATA_W-1:0] cap_q  [CH_NUM];
  logic [DATA_W-1:0] merged [CH_NUM];

  // current slot overlays the stored frame so the last slot needs no extra cycle
  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      merged[c] = cap_q[c];
      for (int l = 0; l < LANES; l++) begin
        if (valid_i && (int'(chan_i) + l == c)) merged[c] = data_i[l*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CH_NUM; c++) cap_q[c] <= '0;
    end else if (valid_i) begin
      for (int c = 0; c < CH_NUM; c++) cap_q[c] <= merged[c];
    end
  end

  assign frame_o = valid_i && (int'(chan_i) + LANES >= CH_NUM);

  for (genvar c = 0; c < CH_NUM; c++) begin : g_flat
    assign frame_data_o[c*DATA_W +: DATA_W] = merged[c];
  end
endmodule

// File: rtl/tdm_emit.sv
module tdm_emit
  import tdm_pkg::*;
#(
  parameter int CH_NUM = 10,
  parameter int DATA_W = 16,
  parameter int LANES  = 4,
  parameter int SLOTS  = 3,
  parameter int CH_W   = 4,
  localparam int SLOT_W = width_of(SLOTS)
)(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [CH_NUM*DATA_W-1:0]   frame_data_i,
  output logic [LANES-1:0]           valid_o,
  output logic [CH_W-1:0]            chan_o,
  output logic                       sof_o,
  output logic [LANES*DATA_W-1:0]    data_o
);
  logic [CH_NUM*DATA_W-1:0] hold_q;
  logic                     busy_q;
  logic [SLOT_W-1:0]        slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      busy_q <= 1'b0;
      slot_q <= '0;
    end else if (load_i) begin
      hold_q <= frame_data_i;
      busy_q <= 1'b1;
      slot_q <= '0;
    end else if (busy_q) begin
      if (slot_q == SLOT_W'(SLOTS - 1)) begin
        busy_q <= 1'b0;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      int  ch;
      logic lane_ok;
      ch      = int'(slot_q) * LANES + l;
      lane_ok = busy_q && (ch < CH_NUM);
      valid_o[l] = lane_ok;
      data_o[l*DATA_W +: DATA_W] = lane_ok ? hold_q[(lane_ok ? ch : 0)*DATA_W +: DATA_W] : '0;
    end
  end

  assign chan_o = busy_q ? CH_W'(int'(slot_q) * LANES) : '0;
  assign sof_o  = busy_q && (slot_q == '0);
endmodule

// File: rtl/tdm_lane_repacker.sv
module tdm_lane_repacker
  import tdm_pkg::*;
#(
  parameter int CH_NUM    = 10,
  parameter int DATA_W    = 16,
  parameter int SMP_RATE  = 20,
  parameter int CLK_RATE  = 100,
  parameter int RATE_UP   = 2,
  parameter int RATE_DOWN = 1,
  localparam int IN_LANES  = ceil_div(CH_NUM * SMP_RATE, CLK_RATE),
  localparam int OUT_LANES = ceil_div(CH_NUM * SMP_RATE * RATE_UP, CLK_RATE * RATE_DOWN),
  localparam int OUT_SLOTS = ceil_div(CH_NUM, OUT_LANES),
  localparam int CH_W      = width_of(CH_NUM)
)(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic [CH_W-1:0]               in_chan_i,
  input  logic [IN_LANES*DATA_W-1:0]    in_data_i,
  output logic [OUT_LANES-1:0]          out_valid_o,
  output logic [CH_W-1:0]               out_chan_o,
  output logic                          out_sof_o,
  output logic [OUT_LANES*DATA_W-1:0]   out_data_o
);
  logic                     frame_done;
  logic [CH_NUM*DATA_W-1:0] frame_data;

  tdm_capture #(
    .CH_NUM (CH_NUM),
    .DATA_W (DATA_W),
    .LANES  (IN_LANES),
    .CH_W   (CH_W)
  ) i_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (in_valid_i),
    .chan_i       (in_chan_i),
    .data_i       (in_data_i),
    .frame_o      (frame_done),
    .frame_data_o (frame_data)
  );

  tdm_emit #(
    .CH_NUM (CH_NUM),
    .DATA_W (DATA_W),
    .LANES  (OUT_LANES),
    .SLOTS  (OUT_SLOTS),
    .CH_W   (CH_W)
  ) i_emit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (frame_done),
    .frame_data_i (frame_data),
    .valid_o      (out_valid_o),
    .chan_o       (out_chan_o),
    .sof_o        (out_sof_o),
    .data_o       (out_data_o)
  );
endmodule

// File: rtl/tdm_lane_repacker_chk.sv
module tdm_lane_repacker_chk #(
  parameter int CH_NUM    = 10,
  parameter int DATA_W    = 16,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 4,
  parameter int CH_W      = 4
)(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic [CH_W-1:0]             in_chan_i,
  input logic [OUT_LANES-1:0]        out_valid_o,
  input logic [CH_W-1:0]             out_chan_o,
  input logic                        out_sof_o,
  input logic [OUT_LANES*DATA_W-1:0] out_data_o
);
  a_r3_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (int'(in_chan_i) + IN_LANES >= CH_NUM)) |=> out_sof_o);

  a_r6_sof_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> (out_chan_o == '0 && out_valid_o[0]));

  a_r4_chan_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0 && !out_sof_o) |->
      ($past(out_valid_o) != '0 && out_chan_o == CH_W'(int'($past(out_chan_o)) + OUT_LANES)));

  a_r5_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0) |-> ($countones(out_valid_o) ==
      (((CH_NUM - int'(out_chan_o)) < OUT_LANES) ? (CH_NUM - int'(out_chan_o)) : OUT_LANES)));

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o == '0) |-> (!out_sof_o && out_chan_o == '0 && out_data_o == '0));
endmodule

bind tdm_lane_repacker tdm_lane_repacker_chk #(
  .CH_NUM    (CH_NUM),
  .DATA_W    (DATA_W),
  .IN_LANES  (IN_LANES),
  .OUT_LANES (OUT_LANES),
  .CH_W      (CH_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_chan_i   (in_chan_i),
  .out_valid_o (out_valid_o),
  .out_chan_o  (out_chan_o),
  .out_sof_o   (out_sof_o),
  .out_data_o  (out_data_o)
);

// File: tb/test_tdm_lane_repacker.sv
module test_tdm_lane_repacker;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_chan = '0;
  logic [31:0] in_data = '0;

  logic [3:0]  i_valid;
  logic [3:0]  i_chan;
  logic        i_sof;
  logic [63:0] i_data;
  logic [0:0]  d_valid;
  logic [3:0]  d_chan;
  logic        d_sof;
  logic [15:0] d_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_lane_repacker i_tdm_lane_repacker (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_chan_i(in_chan), .in_data_i(in_data),
    .out_valid_o(i_valid), .out_chan_o(i_chan), .out_sof_o(i_sof), .out_data_o(i_data)
  );

  tdm_lane_repacker #(.RATE_UP(1), .RATE_DOWN(5)) i_tdm_lane_repacker_dec (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_chan_i(in_chan), .in_data_i(in_data),
    .out_valid_o(d_valid), .out_chan_o(d_chan), .out_sof_o(d_sof), .out_data_o(d_data)
  );

  // base, step, gap-cycle flag
  localparam logic [15:0] FRAME_TAB [4][3] = '{
    '{16'h1000, 16'h0011, 16'h0},
    '{16'hA5A0, 16'h0101, 16'h0},
    '{16'hFFF8, 16'h0003, 16'h1},
    '{16'h0000, 16'h1357, 16'h0}
  };

  function automatic logic [15:0] smp(input logic [15:0] base, input logic [15:0] step, input int ch);
    return base + step * 16'(ch);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step_clk;
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [15:0] base, input logic [15:0] step, input bit gap);
    for (int s = 0; s < 5; s++) begin
      if (gap && s == 2) begin
        in_valid = 1'b0;
        in_chan  = 4'd8;
        in_data  = 32'hDEAD_BEEF;
        step_clk();
      end
      in_valid = 1'b1;
      in_chan  = 4'(2 * s);
      in_data  = {smp(base, step, 2*s + 1), smp(base, step, 2*s)};
      step_clk();
    end
    in_valid = 1'b0;
    in_chan  = '0;
    in_data  = 32'h0BAD_F00D;
  endtask

  // entered in the cycle right after the last input slot
  task automatic check_frame(input logic [15:0] base, input logic [15:0] step, input bit do_dec);
    int n;
    n = do_dec ? NCH : 3;
    for (int s = 0; s < n; s++) begin
      if (s < 3) begin
        chk("R4 chan tag", i_chan, 64'(4 * s));
        chk("R6 sof", i_sof, 64'(s == 0));
        if (s == 0) chk("R3 frame start next cycle", i_sof, 64'd1);
        for (int l = 0; l < 4; l++) begin
          int ch;
          ch = 4 * s + l;
          chk("R5 lane valid", i_valid[l], 64'(ch < NCH));
          chk("R7 round trip data", i_data[l*16 +: 16], (ch < NCH) ? 64'(smp(base, step, ch)) : 64'd0);
        end
      end else begin
        chk("R5 idle after frame", {i_valid, i_sof, i_chan}, 64'd0);
      end
      if (do_dec) begin
        chk("R8 dec chan", d_chan, 64'(s));
        chk("R8 dec valid", d_valid, 64'd1);
        chk("R6 dec sof", d_sof, 64'(s == 0));
        chk("R7 dec data", d_data, 64'(smp(base, step, s)));
      end
      step_clk();
    end
    chk("R5 idle valid/sof/chan", {i_valid, i_sof, i_chan}, 64'd0);
    chk("R5 idle data", i_data, 64'd0);
    if (do_dec) chk("R5 dec idle", {d_valid, d_sof, d_chan, d_data}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    #1;
    chk("R9 reset outputs", {i_valid, i_sof, i_chan, i_data}, 64'd0);
    chk("R9 reset dec outputs", {d_valid, d_sof, d_chan, d_data}, 64'd0);
    chk("R1 input lanes", 64'($bits(in_data) / 16), 64'd2);
    chk("R1 interp output lanes", 64'($bits(i_valid)), 64'd4);
    chk("R1 dec output lanes", 64'($bits(d_valid)), 64'd1);
    repeat (3) step_clk();
    rst_n = 1'b1;
    step_clk();
    chk("R5 idle before first frame", {i_valid, i_sof, i_chan, i_data}, 64'd0);

    // table walk; entry 2 carries an invalid gap cycle (R2)
    for (int i = 0; i < 4; i++) begin
      send_frame(FRAME_TAB[i][0], FRAME_TAB[i][1], FRAME_TAB[i][2][0]);
      check_frame(FRAME_TAB[i][0], FRAME_TAB[i][1], 1'b1);
      repeat (2) step_clk();
    end

    // back-to-back frames: next frame arrives while previous is sent (R3)
    send_frame(16'h2222, 16'h0020, 1'b0);
    fork
      check_frame(16'h2222, 16'h0020, 1'b0);
      send_frame(16'h7000, 16'h0007, 1'b0);
    join
    check_frame(16'h7000, 16'h0007, 1'b0);
    repeat (12) step_clk();
    chk("R5 dec idle after restart", {d_valid, d_sof}, 64'd0);

    // reset in the middle of emission (R9)
    send_frame(16'h3333, 16'h0001, 1'b0);
    chk("R3 sof before reset", i_sof, 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset interp", {i_valid, i_sof, i_chan, i_data}, 64'd0);
    chk("R9 async reset dec", {d_valid, d_sof, d_chan, d_data}, 64'd0);
    step_clk();
    rst_n = 1'b1;
    step_clk();
    chk("R9 quiet after reset", {i_valid, i_sof, d_valid, d_sof}, 64'd0);

    // frame after reset still correct
    send_frame(16'h0F0F, 16'h0F01, 1'b0);
    check_frame(16'h0F0F, 16'h0F01, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule